// File: doc/BRIEF.md
# Configurable Logic Tile with Serial Configuration Chain

This block is one fine-grained tile of an island-style reconfigurable mesh. Each tile holds a 4-input look-up table whose result can be taken straight through or through a clocked storage flop, four input selectors that pick the table inputs from the tracks arriving on the tile's north, east, south and west sides, four output drivers that place the result onto the outgoing tracks, and a switch box of 60 programmable connection points that pass a track from one side to another.

All behaviour comes from a 94-bit configuration word kept in a shift register. While `cfg_en` is high the word moves one place per clock from `scan_in` toward `scan_out`, so the tiles of a mesh form one long chain that a loader fills serially. While loading, the tile drives nothing, so a half-written word cannot cause contention on the tracks. Tracks are split into separate in and out vectors; an outgoing track that nothing drives reads 0.

Track vectors are flat: side s, track t sits at bit `s*TRK + t`, with side numbers north=0, east=1, south=2, west=3.

Top module: `clb_tile`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge moves every configuration bit up by one position and takes `scan_in` into bit 0; `scan_out` always shows bit 93, so a bit reaches `scan_out` 94 edges after entering. While `cfg_en` is low the word does not change.
- R2: `rst_n` low clears the configuration word and the storage flop at once, so all `trk_out` bits and `scan_out` read 0.
- R3: Bits 0 to 15 are the truth table: the table result is bit number {in3,in2,in1,in0}, where in k comes from input selector k.
- R4: Input selector k (k = side number) is the 3-bit field at bits 17+3k to 19+3k; a value v from 0 to 4 picks incoming track v of side k, values 5 and 6 give constant 0, value 7 gives constant 1.
- R5: Bit 16 set routes the result through the storage flop, which samples the table result at each rising edge while `cfg_en` is low and holds while it is high; bit 16 clear passes the table result through combinationally.
- R6: Bit 29+k enables the driver placing the result on outgoing track 0 of side k; bit 33 is a spare bit with no effect on any output.
- R7: Switch bit 34 + 5*p + t, with p = 3*src + (dst > src ? dst-1 : dst), passes incoming track t of side src onto outgoing track t of side dst.
- R8: Every outgoing track is the OR of all enabled drivers and switch points aimed at it, and reads 0 when none is enabled.
- R9: While `cfg_en` is high all `trk_out` bits are 0, whatever the configuration and inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain and storage flop |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Serial configuration output to the next tile |
| trk_in | input | 4*TRK | Incoming tracks, side s track t at bit s*TRK+t |
| trk_out | output | 4*TRK | Outgoing tracks, same layout |

## Verification
The bench builds the tile with its default of five tracks per side, which gives the 94-bit word and makes every configuration field small enough to sweep fully: all 16 table rows under several tables, all eight codes of each input selector, all sixteen driver-enable patterns and each of the 60 switch points one at a time. Randomly filled configuration words then exercise the OR of many simultaneous drivers, and a second word loaded behind a first shows the first emerging on `scan_out` in order.

// File: rtl/clb_tile_pkg.sv
package clb_tile_pkg;
  localparam int LUT_K     = 4;
  localparam int NUM_SIDES = 4;
  localparam int NUM_DIRS  = NUM_SIDES * (NUM_SIDES - 1);

  // Directed side pair index: source side, then destination side skipping the source.
  function automatic int pip_pair(input int src, input int dst);
    return src * (NUM_SIDES - 1) + ((dst > src) ? dst - 1 : dst);
  endfunction
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int W = 94
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         scan_in,
  output logic [W-1:0] cfg,
  output logic         scan_out
);
  logic [W-1:0] cfg_q, cfg_nxt;

  always_comb begin
    cfg_nxt = cfg_q;
    if (shift_en) cfg_nxt = {cfg_q[W-2:0], scan_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_nxt;
  end

  assign cfg      = cfg_q;
  assign scan_out = cfg_q[W-1];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cfg_q)); // R1
endmodule

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int K = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic [2**K-1:0] table_bits,
  input  logic            use_reg,
  input  logic [K-1:0]    sel_in,
  output logic            raw,
  output logic            result
);
  logic q_q, q_nxt;

  assign raw = table_bits[sel_in];

  always_comb begin
    q_nxt = q_q;
    if (!hold) q_nxt = raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_nxt;
  end

  assign result = use_reg ? q_q : raw;

  AST_STORE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(q_q)); // R5
endmodule

// File: rtl/input_select.sv
module input_select #(
  parameter int TRK  = 5,
  parameter int SELW = 3
) (
  input  logic [TRK-1:0]  side_trk,
  input  logic [SELW-1:0] sel,
  output logic            pin
);
  always_comb begin
    pin = &sel;
    for (int t = 0; t < TRK; t++) begin
      if (sel == SELW'(t)) pin = side_trk[t];
    end
  end
endmodule

// File: rtl/switch_box.sv
module switch_box
  import clb_tile_pkg::*;
#(
  parameter int TRK     = 5,
  parameter int OUT_TRK = 0
) (
  input  logic [NUM_SIDES*TRK-1:0] trk_in,
  input  logic [NUM_DIRS*TRK-1:0]  pip_en,
  input  logic [NUM_SIDES-1:0]     drv_en,
  input  logic                     drv_val,
  output logic [NUM_SIDES*TRK-1:0] trk_out
);
  always_comb begin
    trk_out = '0;
    for (int s = 0; s < NUM_SIDES; s++) begin
      for (int d = 0; d < NUM_SIDES; d++) begin
        if (s != d) begin
          for (int t = 0; t < TRK; t++) begin
            if (pip_en[pip_pair(s, d)*TRK + t])
              trk_out[d*TRK + t] = trk_out[d*TRK + t] | trk_in[s*TRK + t];
          end
        end
      end
    end
    for (int k = 0; k < NUM_SIDES; k++) begin
      if (drv_en[k])
        trk_out[k*TRK + OUT_TRK] = trk_out[k*TRK + OUT_TRK] | drv_val;
    end
  end
endmodule

// File: rtl/clb_tile.sv
module clb_tile
  import clb_tile_pkg::*;
#(
  parameter int TRK     = 5,
  parameter int OUT_TRK = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 scan_in,
  output logic                 scan_out,
  input  logic [4*TRK-1:0]     trk_in,
  output logic [4*TRK-1:0]     trk_out
);
  localparam int SELW     = $clog2(TRK + 3);
  localparam int LUT_BITS = 2 ** LUT_K;
  localparam int REG_BIT  = LUT_BITS;
  localparam int SEL_LO   = REG_BIT + 1;
  localparam int OE_LO    = SEL_LO + NUM_SIDES * SELW;
  localparam int SPARE    = OE_LO + NUM_SIDES;
  localparam int PIP_LO   = SPARE + 1;
  localparam int NPIP     = NUM_DIRS * TRK;
  localparam int CFG_W    = PIP_LO + NPIP;

  logic [CFG_W-1:0]     cfg;
  logic [LUT_K-1:0]     lut_in;
  logic                 lut_raw, lut_res;
  logic [4*TRK-1:0]     sb_out;

  cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .scan_in  (scan_in),
    .cfg      (cfg),
    .scan_out (scan_out)
  );

  for (genvar k = 0; k < LUT_K; k++) begin : g_isel
    input_select #(.TRK(TRK), .SELW(SELW)) u_isel (
      .side_trk (trk_in[k*TRK +: TRK]),
      .sel      (cfg[SEL_LO + k*SELW +: SELW]),
      .pin      (lut_in[k])
    );
  end

  lut_cell #(.K(LUT_K)) u_lut (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (cfg_en),
    .table_bits (cfg[LUT_BITS-1:0]),
    .use_reg    (cfg[REG_BIT]),
    .sel_in     (lut_in),
    .raw        (lut_raw),
    .result     (lut_res)
  );

  switch_box #(.TRK(TRK), .OUT_TRK(OUT_TRK)) u_sb (
    .trk_in  (trk_in),
    .pip_en  (cfg[PIP_LO +: NPIP]),
    .drv_en  (cfg[OE_LO +: NUM_SIDES]),
    .drv_val (lut_res),
    .trk_out (sb_out)
  );

  assign trk_out = cfg_en ? '0 : sb_out;

  AST_SCAN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> scan_out == $past(cfg[CFG_W-2])); // R1

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && cfg[PIP_LO +: NPIP] == '0 && cfg[OE_LO +: NUM_SIDES] == '0)
      |-> trk_out == '0); // R8

  AST_BYPASS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cfg[REG_BIT] && cfg[PIP_LO +: NPIP] == '0
      && cfg[OE_LO +: NUM_SIDES] == 4'b0001)
      |-> trk_out[OUT_TRK] == lut_raw); // R3
endmodule

// File: tb/tb_clb_tile.sv
module tb_clb_tile;
  localparam int CLK_P = 10;
  localparam int TRK   = 5;
  localparam int NT    = 4 * TRK;
  localparam int W     = 94;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_en;
  logic          scan_in;
  logic          scan_out;
  logic [NT-1:0] trk_in;
  logic [NT-1:0] trk_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  clb_tile #(.TRK(TRK), .OUT_TRK(0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .scan_in(scan_in),
    .scan_out(scan_out), .trk_in(trk_in), .trk_out(trk_out)
  );

  function automatic int pidx(int s, int d);
    return 3 * s + ((d > s) ? d - 1 : d);
  endfunction

  // Reference output from the requirement text; qv is the stored value.
  function automatic logic [NT-1:0] model(logic [W-1:0] c, logic [NT-1:0] ti, logic qv);
    logic [3:0] ins;
    logic [NT-1:0] o;
    logic res;
    o = '0;
    for (int k = 0; k < 4; k++) begin
      int v;
      v = int'(c[17 + 3*k +: 3]);
      ins[k] = (v < 5) ? ti[k*TRK + v] : (v == 7);
    end
    res = c[16] ? qv : c[ins];
    for (int k = 0; k < 4; k++) if (c[29 + k]) o[k*TRK] = o[k*TRK] | res;
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        if (s != d)
          for (int t = 0; t < TRK; t++)
            if (c[34 + pidx(s, d)*TRK + t]) o[d*TRK + t] = o[d*TRK + t] | ti[s*TRK + t];
    return o;
  endfunction

  function automatic logic [W-1:0] rand_word();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic chk(string req, logic [NT-1:0] act, logic [NT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Shifts a word in, most significant bit first; returns with cfg_en low.
  task automatic load(logic [W-1:0] w);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      scan_in = w[i];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    #1;
  endtask

  function automatic logic [W-1:0] base_word(logic [15:0] tbl);
    logic [W-1:0] c;
    c = '0;
    c[15:0] = tbl;
    c[29] = 1'b1;
    return c;
  endfunction

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [W-1:0] a, b, c;
    logic [15:0] tables [4];
    logic [NT-1:0] base_out;
    tables[0] = 16'h8000; tables[1] = 16'h6996;
    tables[2] = 16'hA5C3; tables[3] = 16'h0001;

    rst_n = 1'b0; cfg_en = 1'b0; scan_in = 1'b0; trk_in = '1;
    #(CLK_P * 3 + 1);
    chk("R2 reset tracks", trk_out, '0);
    chk("R2 reset scan_out", NT'(scan_out), '0);
    @(negedge clk); rst_n = 1'b1;
    trk_in = NT'($urandom);
    #1;
    chk("R2 after release", trk_out, '0);

    // R1: second word pushes first out in order
    a = rand_word(); b = rand_word();
    load(a);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int j = 0; j < W; j++) begin
      chk("R1 scan_out order", NT'(scan_out), NT'(a[W-1-j]));
      if (j == 3) chk("R9 outputs idle while loading", trk_out, '0);
      scan_in = b[W-1-j];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    #1;
    chk("R1 scan_out after load", NT'(scan_out), NT'(b[W-1]));
    base_out = trk_out;
    repeat (5) @(negedge clk);
    chk("R1 word held with cfg_en low", NT'(scan_out), NT'(b[W-1]));
    if (!b[16]) chk("R1 outputs held", trk_out, base_out);

    // R3: exhaustive table rows, selectors on track 0
    foreach (tables[n]) begin
      c = base_word(tables[n]);
      load(c);
      for (int idx = 0; idx < 16; idx++) begin
        logic [NT-1:0] ti;
        ti = NT'($urandom);
        for (int k = 0; k < 4; k++) ti[k*TRK] = idx[k];
        trk_in = ti; #1;
        chk("R3 table row", trk_out, model(c, ti, 1'b0));
      end
    end

    // R4: every selector code on every input
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 8; v++) begin
        logic [15:0] tbl;
        for (int i = 0; i < 16; i++) tbl[i] = i[k];
        c = base_word(tbl);
        c[17 + 3*k +: 3] = 3'(v);
        load(c);
        for (int r = 0; r < 4; r++) begin
          logic [NT-1:0] ti;
          logic e;
          ti = NT'($urandom);
          e = (v < 5) ? ti[k*TRK + v] : (v == 7);
          trk_in = ti; #1;
          chk("R4 selector", trk_out, NT'(e));
        end
      end
    end

    // R5: registered path follows one edge later, bypass is immediate
    c = base_word(16'h8000);
    c[16] = 1'b1;
    load(c);
    trk_in = '0;
    @(negedge clk); #1;
    chk("R5 stored zero", trk_out, '0);
    for (int k = 0; k < 4; k++) trk_in[k*TRK] = 1'b1;
    #1;
    chk("R5 holds before edge", trk_out, '0);
    @(negedge clk); #1;
    chk("R5 updates after edge", trk_out, NT'(1));
    trk_in = '0; #1;
    chk("R5 holds one", trk_out, NT'(1));
    @(negedge clk); #1;
    chk("R5 returns to zero", trk_out, '0);

    // R6: all driver-enable patterns with constant-one table
    for (int m = 0; m < 16; m++) begin
      logic [NT-1:0] e;
      c = '0;
      c[15:0] = 16'hFFFF;
      c[29 +: 4] = 4'(m);
      load(c);
      trk_in = NT'($urandom); #1;
      e = '0;
      for (int k = 0; k < 4; k++) e[k*TRK] = m[k];
      chk("R6 driver enables", trk_out, e);
    end

    // R6: spare bit has no effect
    a = rand_word(); a[16] = 1'b0; a[33] = 1'b0;
    b = a; b[33] = 1'b1;
    for (int r = 0; r < 2; r++) begin
      load(r == 0 ? a : b);
      for (int x = 0; x < 6; x++) begin
        logic [NT-1:0] ti;
        ti = NT'(x * 32'h9E3779B9);
        trk_in = ti; #1;
        chk("R6 spare bit inert", trk_out, model(a, ti, 1'b0));
      end
    end

    // R7: each switch point alone
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        if (s != d)
          for (int t = 0; t < TRK; t++) begin
            logic [NT-1:0] e;
            c = '0;
            c[34 + pidx(s, d)*TRK + t] = 1'b1;
            load(c);
            trk_in = '0; trk_in[s*TRK + t] = 1'b1; #1;
            e = '0; e[d*TRK + t] = 1'b1;
            chk("R7 single point", trk_out, e);
            trk_in = ~trk_in; #1;
            chk("R7 single point low", trk_out, '0);
          end

    // R8: random words, many drivers together
    for (int r = 0; r < 10; r++) begin
      c = rand_word(); c[16] = 1'b0;
      load(c);
      for (int x = 0; x < 12; x++) begin
        logic [NT-1:0] ti;
        ti = NT'($urandom);
        trk_in = ti; #1;
        chk("R8 wired OR", trk_out, model(c, ti, 1'b0));
      end
    end
    c = '0;
    load(c);
    trk_in = '1; #1;
    chk("R8 undriven reads zero", trk_out, '0);

    // R9: fully driving word, then enter config mode
    c = '1; c[16] = 1'b0;
    load(c);
    trk_in = '1; #1;
    chk("R9 active before", trk_out, '1);
    @(negedge clk); cfg_en = 1'b1; scan_in = 1'b1; #1;
    chk("R9 forced idle", trk_out, '0);
    @(negedge clk); #1;
    chk("R9 forced idle after edge", trk_out, '0);
    cfg_en = 1'b0;

    finish_run();
  end
endmodule